// File: doc/BRIEF.md
# Physical Memory Protection Permission Checker

This block decides, for one memory access, which protection entry governs it and what the access may do. Each request carries a byte address, a byte count, the current privilege level and the requested access type (read, write, execute). It is checked against a bank of protection entries. Each entry holds a configuration byte and a word-granular address register. The block returns one of three results: the index of the governing entry, a violation when the access straddles an entry boundary, or a default outcome when nothing matches.

Entries are scanned in order of index, and the first one that decides ends the scan. A lockdown control input swaps the ordinary permission rule for two fixed truth tables, one for machine mode and one for the lower modes. The table index is built from the entry's lock, read, write and execute bits. The result is registered, so it appears one clock after the request. Loading the entry registers, the rules for locking them and raising traps belong to neighbouring logic.

Top module: `pmp_perm_check`

## Requirements
- R1: A request sampled with `reqValid` high at a rising edge produces `rspValid` high after that same edge. With `reqValid` low, `rspValid` is low after the edge.
- R2: With `numEntries` = 0, no matching is done: `rspHit`=0, `rspViolation`=0, `rspAllowed`=3'b111.
- R3: Config byte layout: bit 7 lock, bits 4:3 match mode, bit 2 X, bit 1 W, bit 0 R. Mode 1 (range) matches when the previous entry's register×4 ≤ address < own register×4, with a lower bound of 0 for entry 0. Mode 2 covers the 4 bytes at register×4. Mode 3 covers a naturally aligned region of 2^(t+3) bytes, where t is the number of trailing ones in the register.
- R4: An entry in mode 0 never matches and never causes a violation.
- R5: The lowest-indexed deciding entry wins, and later entries are not consulted.
- R6: If exactly one of the first byte and the last byte (address+size−1) lies in an entry, the result is a violation: `rspViolation`=1, `rspHit`=0, `rspIndex` = that entry, `rspAllowed`=0. An earlier full match takes precedence.
- R7: A size of 0 means unknown. With `xlateOn`=1 the access covers the address up to the end of its 4 KiB page. With `xlateOn`=0 it covers 4 bytes.
- R8: With lockdown clear, machine mode (`reqPriv`=2'b11) gets RWX on an unlocked matching entry. Other modes, and any mode on a locked entry, get the entry's own R/W/X bits.
- R9: With lockdown set, key = {L,R,W,X}. Machine mode (permissions written {X,W,R}) gets: keys 0,1,4,5,6,7,8 none; keys 2,3,14 R+W; keys 9,10 X; keys 11,13 R+X; keys 12,15 R.
- R10: With lockdown set, non-machine modes get: keys 0,8,9,12,13,14 none; keys 1,10,11 X; keys 2,4,15 R; keys 3,6 R+W; key 5 R+X; key 7 R+W+X.
- R11: With entries configured but none matching, machine mode gets `rspAllowed`=3'b111 and other modes get 3'b000.
- R12: `rspGrant` = `rspAllowed` AND the requested type. Both are encoded {X,W,R} in bits 2..0.
- R13: Entries with index ≥ `numEntries` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqAddr | input | AW | Byte address |
| reqSize | input | SZW | Byte count, 0 = unknown |
| reqPriv | input | 2 | Privilege level, 2'b11 = machine |
| reqType | input | 3 | Requested access {X,W,R} |
| xlateOn | input | 1 | Address translation active |
| lockdown | input | 1 | Select the lockdown truth tables |
| numEntries | input | $clog2(N+1) | Number of implemented entries |
| entCfg | input | N*8 | Config bytes, entry i at bits [8i+7:8i] |
| entAddr | input | N*(AW-2) | Word address registers, entry i at slice i |
| rspValid | output | 1 | Result present |
| rspHit | output | 1 | An entry fully matched |
| rspIndex | output | $clog2(N) | Deciding entry |
| rspViolation | output | 1 | Boundary straddle detected |
| rspAllowed | output | 3 | Permitted set {X,W,R} |
| rspGrant | output | 3 | Permitted subset of the request |

## Verification
Straddle detection and first-match priority can both apply in one lookup. In that case the order decides: an access can lie fully inside entry 4 while crossing the edge of the later entry 5, and it must resolve as a hit on entry 4. An access that crosses the top of entry 4 must resolve as a violation on entry 4. The unknown-size rule meets straddle detection in the same cycle when a zero-size access is widened to its page end and that widening carries the last byte out of an entry. Each case is driven as a single request, and the registered index, violation and permissions are compared against values worked out from the requirements.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

  localparam int IDX_W = 8;

  typedef enum logic [1:0] {
    MATCH_OFF   = 2'd0,
    MATCH_RANGE = 2'd1,
    MATCH_WORD  = 2'd2,
    MATCH_POW2  = 2'd3
  } matchMode_e;

  // Strobes from the scan control to the datapath.
  typedef struct packed {
    logic             noRules;
    logic             found;
    logic             split;
    logic [IDX_W-1:0] selIdx;
  } scanStrobe_t;

  // Lockdown table for machine mode; key = {L,R,W,X}, result = {X,W,R}.
  function automatic logic [2:0] lockTableMachine(input logic [3:0] key);
    case (key)
      4'd2, 4'd3, 4'd14:  lockTableMachine = 3'b011;
      4'd9, 4'd10:        lockTableMachine = 3'b100;
      4'd11, 4'd13:       lockTableMachine = 3'b101;
      4'd12, 4'd15:       lockTableMachine = 3'b001;
      default:            lockTableMachine = 3'b000;
    endcase
  endfunction

  // Lockdown table for the lower modes.
  function automatic logic [2:0] lockTableOther(input logic [3:0] key);
    case (key)
      4'd1, 4'd10, 4'd11: lockTableOther = 3'b100;
      4'd2, 4'd4, 4'd15:  lockTableOther = 3'b001;
      4'd3, 4'd6:         lockTableOther = 3'b011;
      4'd5:               lockTableOther = 3'b101;
      4'd7:               lockTableOther = 3'b111;
      default:            lockTableOther = 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/pmp_scan_ctrl.sv
module pmp_scan_ctrl
  import pmp_chk_pkg::*;
#(
  parameter int N  = 16,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  startIn,
  input  logic [N-1:0]  endIn,
  input  logic [CW-1:0] numEntries,
  output scanStrobe_t   strobe
);

  always_comb begin
    logic done;
    done           = 1'b0;
    strobe.noRules = (numEntries == '0);
    strobe.found   = 1'b0;
    strobe.split   = 1'b0;
    strobe.selIdx  = '0;
    for (int i = 0; i < N; i++) begin
      if (!done && (i < int'(numEntries))) begin
        if (startIn[i] ^ endIn[i]) begin
          strobe.split  = 1'b1;
          strobe.selIdx = IDX_W'(i);
          done          = 1'b1;
        end else if (startIn[i] & endIn[i]) begin
          strobe.found  = 1'b1;
          strobe.selIdx = IDX_W'(i);
          done          = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pmp_range_dp.sv
module pmp_range_dp
  import pmp_chk_pkg::*;
#(
  parameter int N          = 16,
  parameter int AW         = 32,
  parameter int SZW        = 13,
  parameter int PAGE_BITS  = 12,
  parameter int WORD_BYTES = 4,
  localparam int RW        = AW - 2,
  localparam int IW        = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [AW-1:0]   reqAddr,
  input  logic [SZW-1:0]  reqSize,
  input  logic [1:0]      reqPriv,
  input  logic [2:0]      reqType,
  input  logic            xlateOn,
  input  logic            lockdown,
  input  logic [N*8-1:0]  entCfg,
  input  logic [N*RW-1:0] entAddr,
  input  scanStrobe_t     strobe,
  output logic [N-1:0]    startIn,
  output logic [N-1:0]    endIn,
  output logic            rspValid,
  output logic            rspHit,
  output logic [IW-1:0]   rspIndex,
  output logic            rspViolation,
  output logic [2:0]      rspAllowed,
  output logic [2:0]      rspGrant
);

  localparam logic [AW-1:0] PAGE_SIZE = AW'(1) << PAGE_BITS;

  logic [AW-1:0] spanBytes;
  logic [AW-1:0] lastAddr;
  logic [7:0]    cfgArr [N];

  always_comb begin
    if (reqSize == '0) begin
      if (xlateOn) spanBytes = PAGE_SIZE - AW'(reqAddr[PAGE_BITS-1:0]);
      else         spanBytes = AW'(WORD_BYTES);
    end else begin
      spanBytes = AW'(reqSize);
    end
    lastAddr = reqAddr + spanBytes - AW'(1);
  end

  function automatic logic inEntry(input logic [1:0] mode,
                                   input logic [RW-1:0] curReg,
                                   input logic [RW-1:0] prevReg,
                                   input logic [AW-1:0] byteAddr);
    logic [RW-1:0] wordAddr;
    logic [RW-1:0] sizeMask;
    wordAddr = byteAddr[AW-1:2];
    sizeMask = curReg ^ (curReg + RW'(1));
    case (matchMode_e'(mode))
      MATCH_RANGE: inEntry = (wordAddr >= prevReg) && (wordAddr < curReg);
      MATCH_WORD:  inEntry = (wordAddr == curReg);
      MATCH_POW2:  inEntry = ((wordAddr | sizeMask) == (curReg | sizeMask));
      default:     inEntry = 1'b0;
    endcase
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [RW-1:0] curReg;
    logic [RW-1:0] prevReg;
    assign curReg = entAddr[g*RW +: RW];
    if (g == 0) begin : g_first
      assign prevReg = '0;
    end else begin : g_rest
      assign prevReg = entAddr[(g-1)*RW +: RW];
    end
    assign cfgArr[g]  = entCfg[g*8 +: 8];
    assign startIn[g] = inEntry(cfgArr[g][4:3], curReg, prevReg, reqAddr);
    assign endIn[g]   = inEntry(cfgArr[g][4:3], curReg, prevReg, lastAddr);
  end

  logic [7:0] selCfg;
  logic       isMachine;
  logic [3:0] lockKey;
  logic [2:0] allowedNext;

  assign selCfg    = cfgArr[strobe.selIdx[IW-1:0]];
  assign isMachine = (reqPriv == 2'b11);
  assign lockKey   = {selCfg[7], selCfg[0], selCfg[1], selCfg[2]};

  always_comb begin
    if (strobe.noRules)            allowedNext = 3'b111;
    else if (strobe.split)         allowedNext = 3'b000;
    else if (!strobe.found)        allowedNext = isMachine ? 3'b111 : 3'b000;
    else if (!lockdown)            allowedNext = (isMachine && !selCfg[7]) ? 3'b111 : selCfg[2:0];
    else if (isMachine)            allowedNext = lockTableMachine(lockKey);
    else                           allowedNext = lockTableOther(lockKey);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid     <= 1'b0;
      rspHit       <= 1'b0;
      rspIndex     <= '0;
      rspViolation <= 1'b0;
      rspAllowed   <= 3'b000;
      rspGrant     <= 3'b000;
    end else begin
      rspValid <= reqValid;
      if (reqValid) begin
        rspHit       <= strobe.found && !strobe.noRules;
        rspViolation <= strobe.split && !strobe.noRules;
        rspIndex     <= strobe.selIdx[IW-1:0];
        rspAllowed   <= allowedNext;
        rspGrant     <= allowedNext & reqType;
      end
    end
  end

endmodule

// File: rtl/pmp_perm_check.sv
module pmp_perm_check
  import pmp_chk_pkg::*;
#(
  parameter int N          = 16,
  parameter int AW         = 32,
  parameter int SZW        = 13,
  parameter int PAGE_BITS  = 12,
  parameter int WORD_BYTES = 4,
  localparam int RW        = AW - 2,
  localparam int CW        = $clog2(N + 1),
  localparam int IW        = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [AW-1:0]   reqAddr,
  input  logic [SZW-1:0]  reqSize,
  input  logic [1:0]      reqPriv,
  input  logic [2:0]      reqType,
  input  logic            xlateOn,
  input  logic            lockdown,
  input  logic [CW-1:0]   numEntries,
  input  logic [N*8-1:0]  entCfg,
  input  logic [N*RW-1:0] entAddr,
  output logic            rspValid,
  output logic            rspHit,
  output logic [IW-1:0]   rspIndex,
  output logic            rspViolation,
  output logic [2:0]      rspAllowed,
  output logic [2:0]      rspGrant
);

  scanStrobe_t  strobe;
  logic [N-1:0] startIn;
  logic [N-1:0] endIn;

  pmp_scan_ctrl #(.N(N), .CW(CW)) u_ctrl (
    .startIn    (startIn),
    .endIn      (endIn),
    .numEntries (numEntries),
    .strobe     (strobe)
  );

  pmp_range_dp #(
    .N(N), .AW(AW), .SZW(SZW), .PAGE_BITS(PAGE_BITS), .WORD_BYTES(WORD_BYTES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqAddr      (reqAddr),
    .reqSize      (reqSize),
    .reqPriv      (reqPriv),
    .reqType      (reqType),
    .xlateOn      (xlateOn),
    .lockdown     (lockdown),
    .entCfg       (entCfg),
    .entAddr      (entAddr),
    .strobe       (strobe),
    .startIn      (startIn),
    .endIn        (endIn),
    .rspValid     (rspValid),
    .rspHit       (rspHit),
    .rspIndex     (rspIndex),
    .rspViolation (rspViolation),
    .rspAllowed   (rspAllowed),
    .rspGrant     (rspGrant)
  );

endmodule

// File: rtl/pmp_perm_check_sva.sv
module pmp_perm_check_sva #(
  parameter int CW = 5,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic [1:0]    reqPriv,
  input logic [2:0]    reqType,
  input logic          lockdown,
  input logic [CW-1:0] numEntries,
  input logic          rspValid,
  input logic          rspHit,
  input logic [IW-1:0] rspIndex,
  input logic          rspViolation,
  input logic [2:0]    rspAllowed,
  input logic [2:0]    rspGrant
);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  a_r2_empty_bank: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && numEntries == '0) |=> (!rspHit && !rspViolation && rspAllowed == 3'b111));

  a_r6_split_denies: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspViolation) |-> (!rspHit && rspAllowed == 3'b000 && rspGrant == 3'b000));

  a_r12_grant_mask: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (rspGrant == (rspAllowed & $past(reqType))));

  a_r13_index_bound: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> ((!rspHit && !rspViolation) || (CW'(rspIndex) < $past(numEntries))));

  a_r9_machine_never_full: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && lockdown && reqPriv == 2'b11) |=> (!rspHit || rspAllowed != 3'b111));

  a_r10_write_needs_read: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && lockdown && reqPriv != 2'b11) |=> (!rspHit || !rspAllowed[1] || rspAllowed[0]));

endmodule

bind pmp_perm_check pmp_perm_check_sva #(.CW(CW), .IW(IW)) u_sva (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqPriv      (reqPriv),
  .reqType      (reqType),
  .lockdown     (lockdown),
  .numEntries   (numEntries),
  .rspValid     (rspValid),
  .rspHit       (rspHit),
  .rspIndex     (rspIndex),
  .rspViolation (rspViolation),
  .rspAllowed   (rspAllowed),
  .rspGrant     (rspGrant)
);

// File: tb/sim_pmp_perm_check.sv
`timescale 1ns/1ps
module sim_pmp_perm_check;

  localparam int N  = 16;
  localparam int AW = 32;
  localparam int RW = AW - 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [31:0]   reqAddr = '0;
  logic [12:0]   reqSize = '0;
  logic [1:0]    reqPriv = '0;
  logic [2:0]    reqType = '0;
  logic          xlateOn = 1'b0;
  logic          lockdown = 1'b0;
  logic [4:0]    numEntries = '0;
  logic [N*8-1:0]  entCfg;
  logic [N*RW-1:0] entAddr;
  logic          rspValid, rspHit, rspViolation;
  logic [3:0]    rspIndex;
  logic [2:0]    rspAllowed, rspGrant;

  logic [7:0]    cfgB [N];
  logic [RW-1:0] aReg [N];

  int compared = 0;
  int mismatched = 0;

  typedef struct {
    string      tag;
    logic       hit;
    logic       viol;
    logic [3:0] idx;
    logic [2:0] allowed;
    logic [2:0] grant;
  } item_t;

  item_t expQ[$];

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      entCfg[i*8 +: 8]   = cfgB[i];
      entAddr[i*RW +: RW] = aReg[i];
    end
  end

  pmp_perm_check u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqPriv(reqPriv), .reqType(reqType),
    .xlateOn(xlateOn), .lockdown(lockdown), .numEntries(numEntries),
    .entCfg(entCfg), .entAddr(entAddr), .rspValid(rspValid),
    .rspHit(rspHit), .rspIndex(rspIndex), .rspViolation(rspViolation),
    .rspAllowed(rspAllowed), .rspGrant(rspGrant)
  );

  function automatic logic [7:0] mkCfg(input logic l, input logic [1:0] m,
                                       input logic x, input logic w, input logic r);
    return {l, 2'b00, m, x, w, r};
  endfunction

  // Expected lockdown tables, from R9 and R10; key {L,R,W,X}, result {X,W,R}.
  function automatic logic [2:0] expMach(input int k);
    case (k)
      2, 3, 14: return 3'b011;
      9, 10:    return 3'b100;
      11, 13:   return 3'b101;
      12, 15:   return 3'b001;
      default:  return 3'b000;
    endcase
  endfunction

  function automatic logic [2:0] expOther(input int k);
    case (k)
      1, 10, 11: return 3'b100;
      2, 4, 15:  return 3'b001;
      3, 6:      return 3'b011;
      5:         return 3'b101;
      7:         return 3'b111;
      default:   return 3'b000;
    endcase
  endfunction

  task automatic send(input logic [31:0] a, input logic [12:0] sz, input logic [1:0] pv,
                      input logic [2:0] ty, input logic xl,
                      input logic eHit, input logic eViol, input logic [3:0] eIdx,
                      input logic [2:0] eAllow, input string tag);
    item_t it;
    @(negedge clk);
    reqAddr = a; reqSize = sz; reqPriv = pv; reqType = ty; xlateOn = xl;
    reqValid = 1'b1;
    it.tag = tag; it.hit = eHit; it.viol = eViol; it.idx = eIdx;
    it.allowed = eAllow; it.grant = eAllow & ty;
    expQ.push_back(it);
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0;
    @(posedge clk);
    #1;
  endtask

  // Monitor: compares each result against the oldest expectation.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rstN && rspValid) begin
        compared++;
        if (expQ.size() == 0) begin
          mismatched++;
          $display("FAIL R1 unexpected result: actual rspValid=1 expected no result");
        end else begin
          item_t e;
          e = expQ.pop_front();
          if (rspHit !== e.hit || rspViolation !== e.viol ||
              ((e.hit || e.viol) && rspIndex !== e.idx) ||
              rspAllowed !== e.allowed || rspGrant !== e.grant) begin
            mismatched++;
            $display("FAIL %s: actual hit=%0b viol=%0b idx=%0d allow=%03b grant=%03b expected hit=%0b viol=%0b idx=%0d allow=%03b grant=%03b",
                     e.tag, rspHit, rspViolation, rspIndex, rspAllowed, rspGrant,
                     e.hit, e.viol, e.idx, e.allowed, e.grant);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    mismatched++;
    $display("FAIL watchdog: actual run still going expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      cfgB[i] = 8'h00;
      aReg[i] = '0;
    end
    // R3 bank: range 0..0x3FF, word at 0x1000, 256 B at 0x2000, off, 4 KiB at 0x3000, 256 B at 0x3000
    cfgB[0] = mkCfg(0, 2'd1, 0, 0, 1); aReg[0] = 30'h100;
    cfgB[1] = mkCfg(0, 2'd2, 0, 1, 1); aReg[1] = 30'h400;
    cfgB[2] = mkCfg(0, 2'd3, 1, 0, 0); aReg[2] = 30'h81F;
    cfgB[3] = mkCfg(0, 2'd0, 1, 1, 1); aReg[3] = 30'h1800;
    cfgB[4] = mkCfg(0, 2'd3, 1, 1, 1); aReg[4] = 30'hDFF;
    cfgB[5] = mkCfg(0, 2'd3, 0, 0, 1); aReg[5] = 30'hC1F;
    cfgB[7] = mkCfg(0, 2'd2, 1, 1, 1); aReg[7] = 30'h1400;

    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    compared++;
    if (rspValid !== 1'b0 || rspHit !== 1'b0 || rspViolation !== 1'b0 || rspAllowed !== 3'b000) begin
      mismatched++;
      $display("FAIL reset: actual valid=%0b hit=%0b viol=%0b allow=%03b expected all zero",
               rspValid, rspHit, rspViolation, rspAllowed);
    end
    @(negedge clk);
    rstN = 1'b1;

    // R2: empty bank
    numEntries = 5'd0;
    send(32'h100, 13'd4, 2'b00, 3'b010, 0, 0, 0, 0, 3'b111, "R2 empty bank");

    numEntries = 5'd6;
    send(32'h100,  13'd4, 2'b00, 3'b001, 0, 1, 0, 0, 3'b001, "R3 R8 range entry read");
    send(32'h100,  13'd4, 2'b00, 3'b010, 0, 1, 0, 0, 3'b001, "R12 write masked");
    send(32'h1000, 13'd4, 2'b00, 3'b011, 0, 1, 0, 1, 3'b011, "R3 word entry");
    send(32'h2080, 13'd4, 2'b01, 3'b100, 0, 1, 0, 2, 3'b100, "R3 pow2 entry");
    send(32'h3FE,  13'd4, 2'b00, 3'b001, 0, 0, 1, 0, 3'b000, "R6 straddle range top");
    send(32'h1002, 13'd4, 2'b00, 3'b001, 0, 0, 1, 1, 3'b000, "R6 straddle word");
    send(32'h20FC, 13'd8, 2'b00, 3'b100, 0, 0, 1, 2, 3'b000, "R6 straddle pow2");
    send(32'h100,  13'd4, 2'b11, 3'b111, 0, 1, 0, 0, 3'b111, "R8 machine unlocked");
    send(32'h8000, 13'd4, 2'b11, 3'b111, 0, 0, 0, 0, 3'b111, "R11 machine no match");
    send(32'h8000, 13'd4, 2'b01, 3'b001, 0, 0, 0, 0, 3'b000, "R11 supervisor no match");
    send(32'h6000, 13'd4, 2'b00, 3'b001, 0, 0, 0, 0, 3'b000, "R4 off entry ignored");
    send(32'h3010, 13'd4, 2'b00, 3'b111, 0, 1, 0, 4, 3'b111, "R5 lower index wins");
    send(32'h30FE, 13'd4, 2'b00, 3'b111, 0, 1, 0, 4, 3'b111, "R5 R6 earlier full match beats later straddle");
    send(32'h3FFE, 13'd4, 2'b00, 3'b001, 0, 0, 1, 4, 3'b000, "R6 straddle pow2 top");
    send(32'h3FC,  13'd0, 2'b00, 3'b001, 0, 1, 0, 0, 3'b001, "R7 unknown size word fits");
    send(32'h3FE,  13'd0, 2'b00, 3'b001, 0, 0, 1, 0, 3'b000, "R7 unknown size word straddles");
    send(32'h100,  13'd0, 2'b00, 3'b001, 1, 0, 1, 0, 3'b000, "R7 unknown size page straddles");
    send(32'h3100, 13'd0, 2'b00, 3'b111, 1, 1, 0, 4, 3'b111, "R7 unknown size page fits");
    send(32'h5000, 13'd4, 2'b00, 3'b111, 0, 0, 0, 0, 3'b000, "R13 entry beyond count ignored");
    numEntries = 5'd8;
    send(32'h5000, 13'd4, 2'b00, 3'b111, 0, 1, 0, 7, 3'b111, "R13 entry inside count");
    numEntries = 5'd6;

    // R8: locked entry restricts machine mode
    cfgB[1] = mkCfg(1, 2'd2, 0, 0, 1);
    send(32'h1000, 13'd4, 2'b11, 3'b111, 0, 1, 0, 1, 3'b001, "R8 machine locked");

    // R9 R10: full lockdown tables on the word entry
    lockdown = 1'b1;
    for (int k = 0; k < 16; k++) begin
      cfgB[1] = mkCfg(k[3], 2'd2, k[0], k[1], k[2]);
      send(32'h1000, 13'd4, 2'b11, 3'b111, 0, 1, 0, 1, expMach(k), $sformatf("R9 machine key %0d", k));
      send(32'h1000, 13'd4, 2'b00, 3'b111, 0, 1, 0, 1, expOther(k), $sformatf("R10 user key %0d", k));
    end
    lockdown = 1'b0;

    idle();
    idle();
    compared++;
    if (expQ.size() != 0 || rspValid !== 1'b0) begin
      mismatched++;
      $display("FAIL R1 drain: actual pending=%0d valid=%0b expected 0 0", expQ.size(), rspValid);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule